// File: doc/BRIEF.md
# Cache-Line Memory Request Engine

This block sits in front of one external-memory controller and lets several client agents share it for block transfers. Each client owns a mailbox. It posts a descriptor into the mailbox: an operation code, an external word address, one or two local-buffer word addresses and a byte count. The engine serves the mailboxes in turn. It moves the data between a local buffer memory and a burst-oriented memory port, and issues each transfer as a single burst of contiguous words.

Besides plain fill and flush transfers, one descriptor can replace a dirty line. The engine first writes the old line from the first local address out to the external address. It then fills the second local address from that same external address. A byte count that is not a multiple of the word size ends with a byte-masked final word, so small writes never need a read-modify-write.

The local buffer port has one cycle of read latency. The command toward memory uses a valid/ready handshake. Write beats follow an accepted write command with a per-beat valid and byte mask. Read beats arrive with a per-beat valid and may have gaps between them.

Top module: `line_xfer_engine`

## Requirements
- R1: After reset every `busy` and `err` bit is 0, and `memCmdValid`, `memWrValid` and `bufWe` are 0.
- R2: Operation code 1 (fill) reads ceil(bytes/4) words from external address `reqExtAddr` as one read command with `memCmdBeats` equal to that word count. It writes them to the local buffer starting at `reqLocA`, with word k going to `reqLocA+k`.
- R3: Operation code 2 (flush) sends ceil(bytes/4) words read from the local buffer at `reqLocA+k` to external memory as one write command at `reqExtAddr`. It sends one `memWrValid` beat per word, in order.
- R4: Operation code 3 (replace) first performs a flush from `reqLocA` to `reqExtAddr`, completing all write beats. It then performs a fill from `reqExtAddr` into `reqLocB`. This gives exactly two commands, the write first and the read second.
- R5: Byte lane i is bits 8i+7..8i of a word. On the final word of a transfer whose byte count has remainder r≠0 modulo 4, only lanes 0..r-1 are enabled (`bufBe` when filling, `memWrMask` when flushing). All other words enable all four lanes.
- R6: A request that is accepted while the mailbox is idle is rejected when its operation code is 0, its byte count is 0, or its byte count exceeds LINE_BYTES. Rejection sets that client's `err`, leaves `busy` at 0 and issues no memory command.
- R7: A legal request sets that client's `busy` and clears its `err`. `busy` stays 1 until the whole request has finished, across both phases of a replace. A `reqValid` pulse on a client whose `busy` is 1 is ignored.
- R8: Pending mailboxes are granted round-robin: the search starts at the client after the one granted last. After reset, client 0 has the highest priority.
- R9: While `memCmdValid` is 1 and `memCmdReady` is 0, the command stays asserted and its address, direction and beat count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NC | Per-client descriptor post strobe |
| reqFunc | input | NC x 2 | Operation code: 1 fill, 2 flush, 3 replace, 0 illegal |
| reqExtAddr | input | NC x EA_W | External word address |
| reqLocA | input | NC x LA_W | First local word address (source of a flush, target of a fill) |
| reqLocB | input | NC x LA_W | Fill target of a replace |
| reqBytes | input | NC x CNT_W | Transfer length in bytes |
| busy | output | NC | Request in progress per client |
| err | output | NC | Last post from this client was rejected |
| bufAddr | output | LA_W | Local buffer word address |
| bufWe | output | 1 | Local buffer write strobe |
| bufBe | output | DATA_W/8 | Local buffer byte enables |
| bufWdata | output | DATA_W | Local buffer write data |
| bufRdata | input | DATA_W | Local buffer read data, one cycle after address |
| memCmdValid | output | 1 | Burst command valid |
| memCmdReady | input | 1 | Burst command accepted |
| memCmdWrite | output | 1 | 1 = write burst, 0 = read burst |
| memCmdAddr | output | EA_W | Burst start word address |
| memCmdBeats | output | CNT_W | Burst length in words |
| memWrValid | output | 1 | Write beat valid |
| memWrData | output | DATA_W | Write beat data |
| memWrMask | output | DATA_W/8 | Write beat byte mask |
| memRdValid | input | 1 | Read beat valid |
| memRdData | input | DATA_W | Read beat data |

## Verification
The bench targets byte counts that end part-way through a word, for fills and for flushes. A wrong tail mask would corrupt the untouched lanes of the last word, or drop real bytes. A replace runs over a line whose external contents differ from the old local line. If the fill came before the write-back, or overlapped it, the new local line would hold stale data, or the command log would show the wrong order. The bench also posts a second request to a busy mailbox and posts illegal descriptors. An engine that let either through would issue extra commands or raise `busy`. A simultaneous post from both clients after one of them was served shows fixed priority as the wrong grant order. A slow `memCmdReady` and gaps between read beats check that the engine neither moves on early nor drops beats.

// File: rtl/lxe_pkg.sv
package lxe_pkg;

  typedef enum logic [1:0] {
    FN_NONE  = 2'd0,
    FN_FILL  = 2'd1,
    FN_FLUSH = 2'd2,
    FN_SWAP  = 2'd3
  } func_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrBeat;
    logic incBeat;
    logic fillSel;
    logic rdBuf;
    logic wrBuf;
  } strobe_t;

endpackage

// File: rtl/lxe_mailbox.sv
module lxe_mailbox #(
  parameter int EA_W       = 16,
  parameter int LA_W       = 8,
  parameter int CNT_W      = 7,
  parameter int LINE_BYTES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqFunc,
  input  logic [EA_W-1:0]  reqExtAddr,
  input  logic [LA_W-1:0]  reqLocA,
  input  logic [LA_W-1:0]  reqLocB,
  input  logic [CNT_W-1:0] reqBytes,
  input  logic             done,
  output logic             busy,
  output logic             err,
  output logic [1:0]       heldFunc,
  output logic [EA_W-1:0]  heldExt,
  output logic [LA_W-1:0]  heldLocA,
  output logic [LA_W-1:0]  heldLocB,
  output logic [CNT_W-1:0] heldBytes
);

  logic legal;
  assign legal = (reqFunc != 2'd0) && (reqBytes != '0) &&
                 (reqBytes <= CNT_W'(LINE_BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      err       <= 1'b0;
      heldFunc  <= '0;
      heldExt   <= '0;
      heldLocA  <= '0;
      heldLocB  <= '0;
      heldBytes <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (reqValid && !busy) begin
      if (legal) begin
        busy      <= 1'b1;
        err       <= 1'b0;
        heldFunc  <= reqFunc;
        heldExt   <= reqExtAddr;
        heldLocA  <= reqLocA;
        heldLocB  <= reqLocB;
        heldBytes <= reqBytes;
      end else begin
        err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lxe_ctrl.sv
module lxe_ctrl
  import lxe_pkg::*;
#(
  parameter  int NC    = 2,
  localparam int CLI_W = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NC-1:0]    busyVec,
  input  func_e            func,
  input  logic             lastBeat,
  input  logic             memCmdReady,
  input  logic             memRdValid,
  output strobe_t          stb,
  output logic [CLI_W-1:0] grantIdx,
  output logic [NC-1:0]    doneVec,
  output logic             memCmdValid,
  output logic             memCmdWrite
);

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WBEAT, S_WDRAIN, S_RBEAT, S_DONE
  } state_e;

  state_e           state;
  logic             fillPhase;
  logic [CLI_W-1:0] grantQ;
  logic [CLI_W-1:0] pick;
  logic             found;
  logic             isWrPhase;

  // round-robin search starting after the last grant
  always_comb begin
    pick  = grantQ;
    found = 1'b0;
    for (int k = 1; k <= NC; k++) begin
      int t;
      t = int'(grantQ) + k;
      if (t >= NC) t = t - NC;
      if (!found && busyVec[t]) begin
        pick  = CLI_W'(t);
        found = 1'b1;
      end
    end
  end

  assign isWrPhase = (func == FN_FLUSH) || (func == FN_SWAP && !fillPhase);
  assign grantIdx  = grantQ;

  always_comb begin
    stb         = '0;
    stb.fillSel = fillPhase;
    memCmdValid = 1'b0;
    memCmdWrite = isWrPhase;
    doneVec     = '0;
    case (state)
      S_CMD: begin
        memCmdValid = 1'b1;
        stb.clrBeat = memCmdReady;
      end
      S_WBEAT: begin
        stb.rdBuf   = 1'b1;
        stb.incBeat = 1'b1;
      end
      S_RBEAT: begin
        stb.wrBuf   = memRdValid;
        stb.incBeat = memRdValid;
      end
      S_DONE:  doneVec[grantQ] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      fillPhase <= 1'b0;
      grantQ    <= CLI_W'(NC - 1);
    end else begin
      case (state)
        S_IDLE: begin
          fillPhase <= 1'b0;
          if (found) begin
            grantQ <= pick;
            state  <= S_CMD;
          end
        end
        S_CMD:
          if (memCmdReady) state <= isWrPhase ? S_WBEAT : S_RBEAT;
        S_WBEAT:
          if (lastBeat) state <= S_WDRAIN;
        S_WDRAIN:
          if (func == FN_SWAP && !fillPhase) begin
            fillPhase <= 1'b1;
            state     <= S_CMD;
          end else begin
            state <= S_DONE;
          end
        S_RBEAT:
          if (memRdValid && lastBeat) state <= S_DONE;
        S_DONE: begin
          fillPhase <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lxe_datapath.sv
module lxe_datapath
  import lxe_pkg::*;
#(
  parameter  int EA_W   = 16,
  parameter  int LA_W   = 8,
  parameter  int CNT_W  = 7,
  parameter  int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [EA_W-1:0]  extAddr,
  input  logic [LA_W-1:0]  locA,
  input  logic [LA_W-1:0]  locB,
  input  logic [CNT_W-1:0] bytes,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [DATA_W-1:0] bufRdata,
  output logic             lastBeat,
  output logic [EA_W-1:0]  memCmdAddr,
  output logic [CNT_W-1:0] memCmdBeats,
  output logic [LA_W-1:0]  bufAddr,
  output logic             bufWe,
  output logic [LANES-1:0] bufBe,
  output logic [DATA_W-1:0] bufWdata,
  output logic             memWrValid,
  output logic [DATA_W-1:0] memWrData,
  output logic [LANES-1:0] memWrMask
);

  logic [CNT_W:0]      roundUp;
  logic [CNT_W-1:0]    beats;
  logic [CNT_W-1:0]    beatIdx;
  logic [LANE_W-1:0]   tail;
  logic [LANES-1:0]    curMask;
  logic [LA_W-1:0]     locCur;

  assign roundUp     = {1'b0, bytes} + (CNT_W + 1)'(LANES - 1);
  assign beats       = CNT_W'(roundUp >> LANE_W);
  assign lastBeat    = (beatIdx == beats - CNT_W'(1));
  assign tail        = LANE_W'(bytes);
  assign memCmdAddr  = extAddr;
  assign memCmdBeats = beats;

  // lane i is live unless this is a short final word and i is past the tail
  always_comb begin
    for (int i = 0; i < LANES; i++)
      curMask[i] = !lastBeat || (tail == '0) || (LANE_W'(i) < tail);
  end

  assign locCur   = stb.fillSel ? locB : locA;
  assign bufAddr  = locCur + LA_W'(beatIdx);
  assign bufWe    = stb.wrBuf;
  assign bufBe    = curMask;
  assign bufWdata = memRdData;
  assign memWrData = bufRdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatIdx    <= '0;
      memWrValid <= 1'b0;
      memWrMask  <= '0;
    end else begin
      if (stb.clrBeat)      beatIdx <= '0;
      else if (stb.incBeat) beatIdx <= beatIdx + CNT_W'(1);
      memWrValid <= stb.rdBuf;
      memWrMask  <= stb.rdBuf ? curMask : '0;
    end
  end

endmodule

// File: rtl/line_xfer_engine.sv
module line_xfer_engine
  import lxe_pkg::*;
#(
  parameter  int NC         = 2,
  parameter  int EA_W       = 16,
  parameter  int LA_W       = 8,
  parameter  int DATA_W     = 32,
  parameter  int LINE_BYTES = 64,
  localparam int CNT_W      = $clog2(LINE_BYTES) + 1,
  localparam int LANES      = DATA_W / 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NC-1:0]              reqValid,
  input  logic [NC-1:0][1:0]         reqFunc,
  input  logic [NC-1:0][EA_W-1:0]    reqExtAddr,
  input  logic [NC-1:0][LA_W-1:0]    reqLocA,
  input  logic [NC-1:0][LA_W-1:0]    reqLocB,
  input  logic [NC-1:0][CNT_W-1:0]   reqBytes,
  output logic [NC-1:0]              busy,
  output logic [NC-1:0]              err,
  output logic [LA_W-1:0]            bufAddr,
  output logic                       bufWe,
  output logic [LANES-1:0]           bufBe,
  output logic [DATA_W-1:0]          bufWdata,
  input  logic [DATA_W-1:0]          bufRdata,
  output logic                       memCmdValid,
  input  logic                       memCmdReady,
  output logic                       memCmdWrite,
  output logic [EA_W-1:0]            memCmdAddr,
  output logic [CNT_W-1:0]           memCmdBeats,
  output logic                       memWrValid,
  output logic [DATA_W-1:0]          memWrData,
  output logic [LANES-1:0]           memWrMask,
  input  logic                       memRdValid,
  input  logic [DATA_W-1:0]          memRdData
);

  localparam int CLI_W = (NC > 1) ? $clog2(NC) : 1;

  logic [1:0]       heldFunc  [NC];
  logic [EA_W-1:0]  heldExt   [NC];
  logic [LA_W-1:0]  heldLocA  [NC];
  logic [LA_W-1:0]  heldLocB  [NC];
  logic [CNT_W-1:0] heldBytes [NC];
  logic [NC-1:0]    doneVec;
  logic [CLI_W-1:0] grantIdx;
  logic             lastBeat;
  strobe_t          stb;

  for (genvar c = 0; c < NC; c++) begin : g_mbx
    lxe_mailbox #(
      .EA_W(EA_W), .LA_W(LA_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)
    ) i_mbx (
      .clk(clk), .rstN(rstN),
      .reqValid(reqValid[c]), .reqFunc(reqFunc[c]),
      .reqExtAddr(reqExtAddr[c]), .reqLocA(reqLocA[c]),
      .reqLocB(reqLocB[c]), .reqBytes(reqBytes[c]),
      .done(doneVec[c]), .busy(busy[c]), .err(err[c]),
      .heldFunc(heldFunc[c]), .heldExt(heldExt[c]),
      .heldLocA(heldLocA[c]), .heldLocB(heldLocB[c]),
      .heldBytes(heldBytes[c])
    );
  end

  lxe_ctrl #(.NC(NC)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .busyVec(busy), .func(func_e'(heldFunc[grantIdx])),
    .lastBeat(lastBeat), .memCmdReady(memCmdReady), .memRdValid(memRdValid),
    .stb(stb), .grantIdx(grantIdx), .doneVec(doneVec),
    .memCmdValid(memCmdValid), .memCmdWrite(memCmdWrite)
  );

  lxe_datapath #(
    .EA_W(EA_W), .LA_W(LA_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .extAddr(heldExt[grantIdx]), .locA(heldLocA[grantIdx]),
    .locB(heldLocB[grantIdx]), .bytes(heldBytes[grantIdx]),
    .memRdData(memRdData), .bufRdata(bufRdata),
    .lastBeat(lastBeat), .memCmdAddr(memCmdAddr), .memCmdBeats(memCmdBeats),
    .bufAddr(bufAddr), .bufWe(bufWe), .bufBe(bufBe), .bufWdata(bufWdata),
    .memWrValid(memWrValid), .memWrData(memWrData), .memWrMask(memWrMask)
  );

endmodule

// File: rtl/lxe_checker.sv
module lxe_checker #(
  parameter int NC         = 2,
  parameter int EA_W       = 16,
  parameter int CNT_W      = 7,
  parameter int LINE_BYTES = 64,
  parameter int LANES      = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NC-1:0]            reqValid,
  input logic [NC-1:0][1:0]       reqFunc,
  input logic [NC-1:0][CNT_W-1:0] reqBytes,
  input logic [NC-1:0]            busy,
  input logic [NC-1:0]            err,
  input logic                     bufWe,
  input logic [LANES-1:0]         bufBe,
  input logic                     memCmdValid,
  input logic                     memCmdReady,
  input logic                     memCmdWrite,
  input logic [EA_W-1:0]          memCmdAddr,
  input logic [CNT_W-1:0]         memCmdBeats,
  input logic                     memWrValid,
  input logic [LANES-1:0]         memWrMask
);

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memCmdValid && !memCmdReady) |=>
      (memCmdValid && $stable(memCmdAddr) && $stable(memCmdWrite) && $stable(memCmdBeats)))
    else $error("command changed while stalled");

  p_cmd_owner_r7: assert property (@(posedge clk) disable iff (!rstN)
    memCmdValid |-> (busy != '0))
    else $error("command issued with no busy mailbox");

  p_wr_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> (memWrMask != '0))
    else $error("write beat with empty mask");

  p_fill_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> (bufBe != '0))
    else $error("buffer write with empty enables");

  p_one_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(bufWe && memWrValid))
    else $error("fill and flush beats overlap");

  for (genvar c = 0; c < NC; c++) begin : g_cli
    p_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[c] && !busy[c] &&
       (reqFunc[c] == 2'd0 || reqBytes[c] == '0 || reqBytes[c] > CNT_W'(LINE_BYTES)))
      |=> (err[c] && !busy[c]))
      else $error("illegal descriptor not rejected");

    p_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[c] && !busy[c] && reqFunc[c] != 2'd0 && reqBytes[c] != '0 &&
       reqBytes[c] <= CNT_W'(LINE_BYTES))
      |=> (busy[c] && !err[c]))
      else $error("legal descriptor not accepted");
  end

endmodule

bind line_xfer_engine lxe_checker #(
  .NC(NC), .EA_W(EA_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES), .LANES(LANES)
) i_lxe_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFunc(reqFunc),
  .reqBytes(reqBytes), .busy(busy), .err(err), .bufWe(bufWe), .bufBe(bufBe),
  .memCmdValid(memCmdValid), .memCmdReady(memCmdReady),
  .memCmdWrite(memCmdWrite), .memCmdAddr(memCmdAddr),
  .memCmdBeats(memCmdBeats), .memWrValid(memWrValid), .memWrMask(memWrMask)
);

// File: tb/test_line_xfer_engine.sv
module test_line_xfer_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NC         = 2;
  localparam int EA_W       = 16;
  localparam int LA_W       = 8;
  localparam int DATA_W     = 32;
  localparam int LINE_BYTES = 64;
  localparam int CNT_W      = $clog2(LINE_BYTES) + 1;
  localparam int LANES      = DATA_W / 8;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0]            reqValid = '0;
  logic [NC-1:0][1:0]       reqFunc = '0;
  logic [NC-1:0][EA_W-1:0]  reqExtAddr = '0;
  logic [NC-1:0][LA_W-1:0]  reqLocA = '0;
  logic [NC-1:0][LA_W-1:0]  reqLocB = '0;
  logic [NC-1:0][CNT_W-1:0] reqBytes = '0;
  logic [NC-1:0]            busy, err;
  logic [LA_W-1:0]          bufAddr;
  logic                     bufWe;
  logic [LANES-1:0]         bufBe;
  logic [DATA_W-1:0]        bufWdata;
  logic [DATA_W-1:0]        bufRdata;
  logic                     memCmdValid, memCmdReady, memCmdWrite;
  logic [EA_W-1:0]          memCmdAddr;
  logic [CNT_W-1:0]         memCmdBeats;
  logic                     memWrValid;
  logic [DATA_W-1:0]        memWrData;
  logic [LANES-1:0]         memWrMask;
  logic                     memRdValid = 1'b0;
  logic [DATA_W-1:0]        memRdData = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  line_xfer_engine #(
    .NC(NC), .EA_W(EA_W), .LA_W(LA_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
  ) i_line_xfer_engine (.*);

  // memory models
  logic [31:0] extMem [0:255];
  logic [31:0] bufMem [0:255];
  int cmdDelay = 0;
  int cmdWait  = 0;
  bit rdGap    = 1'b0;
  bit gapPh    = 1'b0;
  int rdLeft   = 0;
  logic [7:0] rdPtr = '0;
  logic [7:0] wrPtr = '0;
  logic [EA_W-1:0] logAddr [0:63];
  bit              logWr   [0:63];
  int              logBeats[0:63];
  int logN = 0;

  assign memCmdReady = (cmdWait == 0);

  always @(posedge clk) begin
    bufRdata <= bufMem[bufAddr];
    if (bufWe)
      for (int l = 0; l < LANES; l++)
        if (bufBe[l]) bufMem[bufAddr][8*l +: 8] <= bufWdata[8*l +: 8];

    if (!memCmdValid) cmdWait <= cmdDelay;
    else if (cmdWait > 0) cmdWait <= cmdWait - 1;
    else begin
      logAddr[logN]  <= memCmdAddr;
      logWr[logN]    <= memCmdWrite;
      logBeats[logN] <= int'(memCmdBeats);
      logN <= logN + 1;
      cmdWait <= cmdDelay;
      if (memCmdWrite) wrPtr <= memCmdAddr[7:0];
      else begin
        rdLeft <= int'(memCmdBeats);
        rdPtr  <= memCmdAddr[7:0];
      end
    end

    if (memWrValid) begin
      for (int l = 0; l < LANES; l++)
        if (memWrMask[l]) extMem[wrPtr][8*l +: 8] <= memWrData[8*l +: 8];
      wrPtr <= wrPtr + 8'd1;
    end

    memRdValid <= 1'b0;
    if (rdLeft > 0) begin
      if (rdGap && !gapPh) gapPh <= 1'b1;
      else begin
        gapPh      <= 1'b0;
        memRdValid <= 1'b1;
        memRdData  <= extMem[rdPtr];
        rdPtr      <= rdPtr + 8'd1;
        rdLeft     <= rdLeft - 1;
      end
    end
  end

  int nChecks = 0;
  int nErr    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic submit(input int c, input logic [1:0] f, input logic [EA_W-1:0] ea,
                        input logic [LA_W-1:0] la, input logic [LA_W-1:0] lb,
                        input int nb);
    @(negedge clk);
    reqFunc[c] = f; reqExtAddr[c] = ea; reqLocA[c] = la; reqLocB[c] = lb;
    reqBytes[c] = CNT_W'(nb);
    reqValid[c] = 1'b1;
    @(negedge clk);
    reqValid = '0;
  endtask

  task automatic waitIdle();
    int n = 0;
    @(negedge clk);
    while (busy != '0 && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == '0 && err == '0, "R1", "mailbox flags", {busy, err}, 0);
    chk(!memCmdValid && !memWrValid && !bufWe, "R1", "strobes",
        {memCmdValid, memWrValid, bufWe}, 0);
  endtask

  task automatic t_fill_full();
    int base = logN;
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      extMem[16 + i] = 32'h1000_0000 + i * 32'h0101_0101;
      bufMem[8'h10 + i] = '0;
    end
    submit(0, 2'd1, 16'd16, 8'h10, 8'h00, 64);
    waitIdle();
    for (int i = 0; i < 16; i++) if (bufMem[8'h10 + i] !== extMem[16 + i]) bad++;
    chk(bad == 0, "R2", "fill words mismatched", bad, 0);
    chk(logN - base == 1 && !logWr[base], "R2", "one read command", logN - base, 1);
    chk(logBeats[base] == 16 && logAddr[base] == 16, "R2", "beats", logBeats[base], 16);
  endtask

  task automatic t_flush_partial();
    int base = logN;
    cmdDelay = 3;
    for (int i = 0; i < 4; i++) extMem[8'h80 + i] = 32'hAAAA_AAAA;
    bufMem[8'h40] = 32'h1122_3344;
    bufMem[8'h41] = 32'h5566_7788;
    bufMem[8'h42] = 32'h99BB_CCDD;
    submit(1, 2'd2, 16'h80, 8'h40, 8'h00, 10);
    waitIdle();
    cmdDelay = 0;
    chk(extMem[8'h80] == 32'h1122_3344 && extMem[8'h81] == 32'h5566_7788,
        "R3", "flush full words", extMem[8'h81], 32'h5566_7788);
    chk(extMem[8'h82] == 32'hAAAA_CCDD, "R5", "flush tail mask", extMem[8'h82], 32'hAAAA_CCDD);
    chk(extMem[8'h83] == 32'hAAAA_AAAA, "R3", "word past end", extMem[8'h83], 32'hAAAA_AAAA);
    chk(logN - base == 1 && logWr[base] && logBeats[base] == 3, "R3", "write command beats",
        logBeats[base], 3);
  endtask

  task automatic t_fill_partial();
    rdGap = 1'b1;
    extMem[8'h20] = 32'hDEAD_BEEF;
    extMem[8'h21] = 32'hCAFE_F00D;
    bufMem[8'h60] = 32'h5555_5555;
    bufMem[8'h61] = 32'h5555_5555;
    submit(0, 2'd1, 16'h20, 8'h60, 8'h00, 7);
    waitIdle();
    rdGap = 1'b0;
    chk(bufMem[8'h60] == 32'hDEAD_BEEF, "R2", "fill with gaps", bufMem[8'h60], 32'hDEAD_BEEF);
    chk(bufMem[8'h61] == 32'h55FE_F00D, "R5", "fill tail mask", bufMem[8'h61], 32'h55FE_F00D);
  endtask

  task automatic t_swap_busy();
    int base = logN;
    int bad = 0;
    int n = 0;
    for (int i = 0; i < 4; i++) begin
      extMem[8'h30 + i] = 32'h0BAD_0000 + i;
      bufMem[8'h70 + i] = 32'h600D_0000 + i;
      bufMem[8'h90 + i] = '0;
    end
    submit(0, 2'd3, 16'h30, 8'h70, 8'h90, 16);
    while (logN == base && n < 500) begin @(negedge clk); n++; end
    chk(busy[0] == 1'b1, "R7", "busy during replace", busy[0], 1);
    submit(0, 2'd1, 16'h50, 8'hA0, 8'h00, 4);  // ignored while busy
    waitIdle();
    for (int i = 0; i < 4; i++)
      if (extMem[8'h30 + i] !== 32'h600D_0000 + i || bufMem[8'h90 + i] !== 32'h600D_0000 + i) bad++;
    chk(bad == 0, "R4", "replace data (write-back before fill)", bad, 0);
    chk(logN - base == 2, "R7", "second post ignored", logN - base, 2);
    chk(logWr[base] && !logWr[base + 1], "R4", "write then read order",
        {logWr[base], logWr[base + 1]}, 2'b10);
    chk(logAddr[base + 1] == 16'h30 && err[0] == 1'b0, "R4", "fill address", logAddr[base + 1], 16'h30);
  endtask

  task automatic t_illegal();
    int base = logN;
    submit(1, 2'd0, 16'h10, 8'h00, 8'h00, 8);
    repeat (20) @(negedge clk);
    chk(err[1] && !busy[1], "R6", "code 0 rejected", {err[1], busy[1]}, 2'b10);
    submit(1, 2'd1, 16'h10, 8'h00, 8'h00, 0);
    repeat (5) @(negedge clk);
    chk(err[1] && !busy[1], "R6", "zero count rejected", {err[1], busy[1]}, 2'b10);
    submit(1, 2'd2, 16'h10, 8'h00, 8'h00, 65);
    repeat (5) @(negedge clk);
    chk(err[1] && !busy[1], "R6", "oversize rejected", {err[1], busy[1]}, 2'b10);
    chk(logN == base, "R6", "no command issued", logN - base, 0);
    submit(1, 2'd1, 16'h10, 8'hC0, 8'h00, 4);
    chk(!err[1], "R7", "legal post clears err", err[1], 0);
    waitIdle();
    chk(logN - base == 1, "R7", "legal post served", logN - base, 1);
  endtask

  task automatic t_round_robin();
    int base;
    submit(0, 2'd1, 16'h04, 8'hD0, 8'h00, 4);
    waitIdle();
    base = logN;
    @(negedge clk);
    reqFunc[0] = 2'd1; reqExtAddr[0] = 16'h08; reqLocA[0] = 8'hD4; reqBytes[0] = CNT_W'(4);
    reqFunc[1] = 2'd1; reqExtAddr[1] = 16'h0C; reqLocA[1] = 8'hD8; reqBytes[1] = CNT_W'(4);
    reqValid = '1;
    @(negedge clk);
    reqValid = '0;
    waitIdle();
    chk(logN - base == 2, "R8", "both served", logN - base, 2);
    chk(logAddr[base] == 16'h0C && logAddr[base + 1] == 16'h08, "R8",
        "client after last grant goes first", logAddr[base], 16'h0C);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin extMem[i] = '0; bufMem[i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fill_full();
    t_flush_partial();
    t_fill_partial();
    t_swap_busy();
    t_illegal();
    t_round_robin();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule